// File: doc/BRIEF.md
# Split-Half Store Buffer with Load Forwarding

This block holds pending stores between dispatch and the cache. A store takes a slot in program order. Its address half and its data half then arrive as two separate micro-operations. They can arrive in either order, or both in one cycle. Each slot runs a small state machine that records which halves have arrived. The slot stays in the buffer until the store retires. After that it drains, oldest first, to a downstream write port.

Loads query the buffer combinationally. The load supplies the allocation tag that was current when it dispatched, so only stores older than the load are considered. The youngest older store that decides the outcome selects the result code:
- forward the data,
- replay, because a half is still missing,
- block until the store has drained, because the overlap cannot be served,
- no match, so the load reads the cache.

A flush discards every store that has not retired. Retired stores keep draining.

Top module: `sb_split_fwd`

Slot states: `E_FREE`, `E_WAIT_BOTH`, `E_HAVE_ADDR` (address known, data pending), `E_HAVE_DATA` (data known, address pending), `E_READY`, `E_RETIRED`. Transitions:
- allocate: FREE→WAIT_BOTH
- address write: WAIT_BOTH→HAVE_ADDR, or HAVE_DATA→READY
- data write: WAIT_BOTH→HAVE_DATA, or HAVE_ADDR→READY
- both writes in one cycle: WAIT_BOTH→READY
- retire: READY→RETIRED
- drain: RETIRED→FREE
- flush: any non-free, non-retired state→FREE

## Requirements
- R1: Slots are allocated at the tail. `alloc_tag` shows the tail pointer, with the slot index in its low 3 bits and a wrap bit above them. `alloc_ready` is low while 8 slots are live, and an allocation request in that condition is ignored.
- R2: A slot accepts its address half and its data half in either order, or both in the same cycle. It can forward only once both halves are present.
- R3: A `retire` pulse moves the oldest unretired slot to retired only if both of its halves are present. Otherwise the pulse is ignored.
- R4: The oldest retired slot is offered on the drain port with its address, size and data. It leaves on a cycle where `drain_ready` is high, at most one slot per cycle. While it waits, the offer holds steady.
- R5: A load considers only the slots at offsets below `(ld_snap - head) mod 16` from the oldest live slot. If that value exceeds the occupancy, the load considers no slot.
- R6: `ld_res` uses the codes 00 = no match, 01 = forwarded, 10 = replay, 11 = block. It is 00 whenever `ld_valid` is low.
- R7: Among the considered slots, the youngest one whose address is unknown or whose bytes overlap the load decides the result.
- R8: If the deciding slot's address half is missing, the result is replay.
- R9: If the deciding slot's address overlaps the load but its data half is missing, the result is replay.
- R10: The result is forwarded when the deciding slot has data, starts at the load's address, and has a size no smaller than the load's. `ld_data` then holds the low load-size bytes of the store data, with zeros above them.
- R11: The result is block when the deciding slot has data and overlaps the load in any other way.
- R12: `flush` frees every unretired slot and moves the tail back to the retire point. Retired slots stay and still drain. An allocation in the same cycle is dropped.
- R13: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. `ld_data` is zero unless the result is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Buffer not full |
| alloc_tag | output | 4 | Tail pointer with wrap bit; low 3 bits are the slot index |
| sta_valid | input | 1 | Address-half write |
| sta_idx | input | 3 | Slot for the address half |
| sta_addr | input | 16 | Store byte address |
| sta_size | input | 2 | Store size code |
| std_valid | input | 1 | Data-half write |
| std_idx | input | 3 | Slot for the data half |
| std_data | input | 32 | Store data, little-endian in the low bytes |
| retire | input | 1 | Retire the oldest unretired store |
| flush | input | 1 | Discard unretired stores |
| ld_valid | input | 1 | Load lookup |
| ld_addr | input | 16 | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_snap | input | 4 | Allocation tag captured when the load dispatched |
| ld_res | output | 2 | Lookup result code |
| ld_data | output | 32 | Forwarded data |
| drain_valid | output | 1 | Retired store offered downstream |
| drain_ready | input | 1 | Downstream accepts |
| drain_addr | output | 16 | Drained store address |
| drain_size | output | 2 | Drained store size code |
| drain_data | output | 32 | Drained store data |

## Verification
The hardest case to reach is the one where the deciding slot is not the only candidate. For example, a younger partial store must hide an older forwardable one, or the load tag must fall just outside the live window. Directed sequences build those layouts on purpose: a data-first store, then a one-byte store inside the four-byte one, queried with tags one slot apart and one slot before the head.

A long random phase then draws addresses from an eight-byte space, so that overlaps are common. It takes tags up to two slots behind the tail and now and then one before the head. It mixes in occasional flushes beside retires, and a random drain ready, and compares every output each cycle against a bench model.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [2:0] {
        E_FREE,
        E_WAIT_BOTH,
        E_HAVE_ADDR,
        E_HAVE_DATA,
        E_READY,
        E_RETIRED
    } slot_state_e;

    typedef enum logic [1:0] {
        LD_NONE   = 2'b00,
        LD_FWD    = 2'b01,
        LD_REPLAY = 2'b10,
        LD_BLOCK  = 2'b11
    } ld_res_e;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic has_addr(input slot_state_e s);
        has_addr = (s == E_HAVE_ADDR) || (s == E_READY) || (s == E_RETIRED);
    endfunction

    function automatic logic has_data(input slot_state_e s);
        has_data = (s == E_HAVE_DATA) || (s == E_READY) || (s == E_RETIRED);
    endfunction

endpackage

// File: rtl/sb_slot.sv
module sb_slot
    import sb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_hit,
    input  logic          sta_hit,
    input  logic [AW-1:0] sta_addr,
    input  logic [1:0]    sta_size,
    input  logic          std_hit,
    input  logic [DW-1:0] std_data,
    input  logic          retire_hit,
    input  logic          drain_hit,
    input  logic          flush,
    output slot_state_e   state_o,
    output logic [AW-1:0] addr_o,
    output logic [1:0]    size_o,
    output logic [DW-1:0] data_o
);

    slot_state_e st_q, st_d;
    logic        take_addr, take_data;
    logic [AW-1:0] addr_q;
    logic [1:0]    size_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= E_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        take_addr = sta_hit && !flush && (st_q == E_WAIT_BOTH || st_q == E_HAVE_DATA);
        take_data = std_hit && !flush && (st_q == E_WAIT_BOTH || st_q == E_HAVE_ADDR);
        st_d = st_q;
        unique case (st_q)
            E_FREE:      if (alloc_hit) st_d = E_WAIT_BOTH;
            E_WAIT_BOTH: begin
                if (take_addr && take_data) st_d = E_READY;
                else if (take_addr)         st_d = E_HAVE_ADDR;
                else if (take_data)         st_d = E_HAVE_DATA;
            end
            E_HAVE_ADDR: if (take_data)  st_d = E_READY;
            E_HAVE_DATA: if (take_addr)  st_d = E_READY;
            E_READY:     if (retire_hit) st_d = E_RETIRED;
            E_RETIRED:   if (drain_hit)  st_d = E_FREE;
            default:     st_d = E_FREE;
        endcase
        if (flush && st_q != E_FREE && st_q != E_RETIRED && !retire_hit)
            st_d = E_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= '0;
            data_q <= '0;
        end else begin
            if (take_addr) begin
                addr_q <= sta_addr;
                size_q <= sta_size;
            end
            if (take_data) data_q <= std_data;
        end
    end

    always_comb begin
        state_o = st_q;
        addr_o  = addr_q;
        size_o  = size_q;
        data_o  = data_q;
    end

    // R3: only a ready slot may become retired
    a_r3_retire_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != E_RETIRED && st_q != E_READY) |=> (st_q != E_RETIRED));

    // R12: a retired slot survives flush until drained
    a_r12_retired_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == E_RETIRED && !drain_hit) |=> (st_q == E_RETIRED));

    // R2: both halves are needed to become ready
    a_r2_ready_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == E_WAIT_BOTH && !(sta_hit && std_hit)) |=> (st_q != E_READY));

endmodule

// File: rtl/sb_lookup.sv
module sb_lookup
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1,
    localparam int NB   = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_state_e   slot_st   [DEPTH],
    input  logic [AW-1:0] slot_addr [DEPTH],
    input  logic [1:0]    slot_size [DEPTH],
    input  logic [DW-1:0] slot_data [DEPTH],
    input  logic [PW-1:0] head_ptr,
    input  logic [PW-1:0] count,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [1:0]    ld_size,
    input  logic [PW-1:0] ld_snap,
    output logic [1:0]    res_o,
    output logic [DW-1:0] data_o
);

    logic [PW-1:0] span, win;
    logic [IW-1:0] pos;
    logic [AW:0]   s_lo, s_hi, l_lo, l_hi;
    logic          ovl;
    ld_res_e       res;
    logic [DW-1:0] hit_data, mask;

    always_comb begin
        span     = ld_snap - head_ptr;
        win      = (span > count) ? '0 : span;
        res      = LD_NONE;
        hit_data = '0;
        pos      = '0;
        s_lo     = '0;
        s_hi     = '0;
        ovl      = 1'b0;
        l_lo     = {1'b0, ld_addr};
        l_hi     = l_lo + (AW+1)'(size_bytes(ld_size));
        for (int k = 0; k < DEPTH; k++) begin
            if (ld_valid && (PW'(k) < win)) begin
                pos  = head_ptr[IW-1:0] + IW'(k);
                s_lo = {1'b0, slot_addr[pos]};
                s_hi = s_lo + (AW+1)'(size_bytes(slot_size[pos]));
                ovl  = (s_lo < l_hi) && (l_lo < s_hi);
                if (!has_addr(slot_st[pos])) begin
                    res = LD_REPLAY;
                end else if (ovl) begin
                    if (!has_data(slot_st[pos])) begin
                        res = LD_REPLAY;
                    end else if (s_lo == l_lo &&
                                 size_bytes(slot_size[pos]) >= size_bytes(ld_size)) begin
                        res      = LD_FWD;
                        hit_data = slot_data[pos];
                    end else begin
                        res = LD_BLOCK;
                    end
                end
            end
        end
    end

    always_comb begin
        mask = '0;
        for (int b = 0; b < NB; b++)
            mask[b*8 +: 8] = (b < int'(size_bytes(ld_size))) ? 8'hFF : 8'h00;
    end

    always_comb begin
        res_o  = res;
        data_o = (res == LD_FWD) ? (hit_data & mask) : '0;
    end

    // R13: data lines are quiet unless a forward happens
    a_r13_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        (res_o != 2'b01) |-> (data_o == '0));

    // R6: no lookup, no result
    a_r6_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> (res_o == 2'b00));

    // R5: a non-zero result needs a non-empty window
    a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
        (res_o != 2'b00) |-> (win != '0));

endmodule

// File: rtl/sb_split_fwd.sv
module sb_split_fwd
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    output logic          alloc_ready,
    output logic [PW-1:0] alloc_tag,
    input  logic          sta_valid,
    input  logic [IW-1:0] sta_idx,
    input  logic [AW-1:0] sta_addr,
    input  logic [1:0]    sta_size,
    input  logic          std_valid,
    input  logic [IW-1:0] std_idx,
    input  logic [DW-1:0] std_data,
    input  logic          retire,
    input  logic          flush,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [1:0]    ld_size,
    input  logic [PW-1:0] ld_snap,
    output logic [1:0]    ld_res,
    output logic [DW-1:0] ld_data,
    output logic          drain_valid,
    input  logic          drain_ready,
    output logic [AW-1:0] drain_addr,
    output logic [1:0]    drain_size,
    output logic [DW-1:0] drain_data
);

    logic [PW-1:0] head_q, ret_q, tail_q;
    logic [PW-1:0] head_d, ret_d, tail_d;
    logic [PW-1:0] count;
    logic          full, alloc_ok, retire_ok, drain_ok;

    slot_state_e   slot_st   [DEPTH];
    logic [AW-1:0] slot_addr [DEPTH];
    logic [1:0]    slot_size [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];

    always_comb begin
        count     = tail_q - head_q;
        full      = (count == PW'(DEPTH));
        alloc_ok  = alloc_valid && !full && !flush;
        retire_ok = retire && (ret_q != tail_q) && (slot_st[ret_q[IW-1:0]] == E_READY);
        drain_ok  = (slot_st[head_q[IW-1:0]] == E_RETIRED) && drain_ready;
        head_d    = head_q + PW'(drain_ok);
        ret_d     = ret_q + PW'(retire_ok);
        tail_d    = flush ? ret_d : (tail_q + PW'(alloc_ok));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            ret_q  <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_d;
            ret_q  <= ret_d;
            tail_q <= tail_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sb_slot #(.AW(AW), .DW(DW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_hit  (alloc_ok && tail_q[IW-1:0] == IW'(g)),
            .sta_hit    (sta_valid && sta_idx == IW'(g)),
            .sta_addr   (sta_addr),
            .sta_size   (sta_size),
            .std_hit    (std_valid && std_idx == IW'(g)),
            .std_data   (std_data),
            .retire_hit (retire_ok && ret_q[IW-1:0] == IW'(g)),
            .drain_hit  (drain_ok && head_q[IW-1:0] == IW'(g)),
            .flush      (flush),
            .state_o    (slot_st[g]),
            .addr_o     (slot_addr[g]),
            .size_o     (slot_size[g]),
            .data_o     (slot_data[g])
        );
    end

    sb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_st   (slot_st),
        .slot_addr (slot_addr),
        .slot_size (slot_size),
        .slot_data (slot_data),
        .head_ptr  (head_q),
        .count     (count),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_size   (ld_size),
        .ld_snap   (ld_snap),
        .res_o     (ld_res),
        .data_o    (ld_data)
    );

    always_comb begin
        alloc_ready = !full;
        alloc_tag   = tail_q;
        drain_valid = (slot_st[head_q[IW-1:0]] == E_RETIRED);
        drain_addr  = slot_addr[head_q[IW-1:0]];
        drain_size  = slot_size[head_q[IW-1:0]];
        drain_data  = slot_data[head_q[IW-1:0]];
    end

    // R1: occupancy never exceeds the slot count
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= PW'(DEPTH)));

    // R1: a full buffer does not move its tail on a request
    a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !flush) |=> $stable(tail_q));

    // R4: a stalled drain offer is held
    a_r4_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ready) |=>
            (drain_valid && $stable(drain_addr) && $stable(drain_data)));

    // R12: after flush the tail sits at the retire point
    a_r12_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tail_q == ret_q));

endmodule

// File: tb/tb_sb_split_fwd.sv
module tb_sb_split_fwd;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid, alloc_ready;
    logic [3:0]  alloc_tag;
    logic        sta_valid, std_valid, retire, flush, ld_valid, drain_ready, drain_valid;
    logic [2:0]  sta_idx, std_idx;
    logic [15:0] sta_addr, ld_addr, drain_addr;
    logic [1:0]  sta_size, ld_size, ld_res, drain_size;
    logic [31:0] std_data, ld_data, drain_data;
    logic [3:0]  ld_snap;

    int n_cmp = 0;
    int n_bad = 0;

    // model: 0 free, 1 wait both, 2 have addr, 3 have data, 4 ready, 5 retired
    int          mst  [8];
    logic [15:0] maddr[8];
    logic [1:0]  msz  [8];
    logic [31:0] mdat [8];
    logic [3:0]  mh, mr, mt;

    always #10 clk = ~clk;

    sb_split_fwd dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .sta_valid(sta_valid), .sta_idx(sta_idx), .sta_addr(sta_addr), .sta_size(sta_size),
        .std_valid(std_valid), .std_idx(std_idx), .std_data(std_data),
        .retire(retire), .flush(flush),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size), .ld_snap(ld_snap),
        .ld_res(ld_res), .ld_data(ld_data),
        .drain_valid(drain_valid), .drain_ready(drain_ready),
        .drain_addr(drain_addr), .drain_size(drain_size), .drain_data(drain_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nbytes(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic model_lookup(output logic [1:0] res, output logic [31:0] dat, output string tag);
        logic [3:0] span, cnt;
        int lb, la, sa, sb, idx;
        res = 2'b00; dat = '0; tag = ld_valid ? "R5" : "R6";
        span = ld_snap - mh;
        cnt  = mt - mh;
        if (span > cnt) span = 4'd0;
        if (!ld_valid) span = 4'd0;
        la = int'(ld_addr); lb = nbytes(ld_size);
        for (int k = 0; k < 8; k++) begin
            if (k < int'(span)) begin
                idx = (int'(mh) + k) % 8;
                sa = int'(maddr[idx]); sb = nbytes(msz[idx]);
                if (!(mst[idx] == 2 || mst[idx] == 4 || mst[idx] == 5)) begin
                    res = 2'b10; dat = '0; tag = "R8";
                end else if (sa < la + lb && la < sa + sb) begin
                    if (!(mst[idx] == 3 || mst[idx] == 4 || mst[idx] == 5)) begin
                        res = 2'b10; dat = '0; tag = "R9";
                    end else if (sa == la && sb >= lb) begin
                        res = 2'b01; tag = "R10";
                        dat = (lb == 4) ? mdat[idx] : (mdat[idx] & ((32'd1 << (8*lb)) - 32'd1));
                    end else begin
                        res = 2'b11; dat = '0; tag = "R11";
                    end
                end
            end
        end
    endtask

    // sample outputs well after the negedge drive, before the next posedge
    task automatic settle();
        logic [1:0] er; logic [31:0] ed; string tg;
        logic [3:0] cnt;
        #8;
        cnt = mt - mh;
        chk("R1 alloc_ready", {31'd0, alloc_ready}, {31'd0, cnt != 4'd8});
        chk("R1 alloc_tag", {28'd0, alloc_tag}, {28'd0, mt});
        chk("R4 drain_valid", {31'd0, drain_valid}, {31'd0, mst[mh[2:0]] == 5});
        if (mst[mh[2:0]] == 5) begin
            chk("R4 drain_addr", {16'd0, drain_addr}, {16'd0, maddr[mh[2:0]]});
            chk("R4 drain_size", {30'd0, drain_size}, {30'd0, msz[mh[2:0]]});
            chk("R4 drain_data", drain_data, mdat[mh[2:0]]);
        end
        model_lookup(er, ed, tg);
        chk({tg, " ld_res"}, {30'd0, ld_res}, {30'd0, er});
        chk("R13 ld_data", ld_data, ed);
    endtask

    task automatic advance();
        int ns[8];
        logic [3:0] cnt;
        logic a_ok, r_ok, d_ok, ta, td;
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mst[i] = 0;
            mh = 0; mr = 0; mt = 0;
        end else begin
            cnt  = mt - mh;
            a_ok = alloc_valid && cnt != 4'd8 && !flush;
            r_ok = retire && mr != mt && mst[mr[2:0]] == 4;
            d_ok = mst[mh[2:0]] == 5 && drain_ready;
            for (int i = 0; i < 8; i++) begin
                ns[i] = mst[i];
                ta = sta_valid && !flush && int'(sta_idx) == i && (mst[i] == 1 || mst[i] == 3);
                td = std_valid && !flush && int'(std_idx) == i && (mst[i] == 1 || mst[i] == 2);
                if (mst[i] == 0 && a_ok && int'(mt[2:0]) == i) ns[i] = 1;
                if (mst[i] == 1) ns[i] = (ta && td) ? 4 : ta ? 2 : td ? 3 : 1;
                if (mst[i] == 2 && td) ns[i] = 4;
                if (mst[i] == 3 && ta) ns[i] = 4;
                if (mst[i] == 4 && r_ok && int'(mr[2:0]) == i) ns[i] = 5;
                if (mst[i] == 5 && d_ok && int'(mh[2:0]) == i) ns[i] = 0;
                if (flush && mst[i] != 0 && mst[i] != 5 && !(r_ok && int'(mr[2:0]) == i)) ns[i] = 0;
                if (ta) begin maddr[i] = sta_addr; msz[i] = sta_size; end
                if (td) mdat[i] = std_data;
            end
            for (int i = 0; i < 8; i++) mst[i] = ns[i];
            mh = mh + 4'(d_ok);
            mr = mr + 4'(r_ok);
            mt = flush ? mr : mt + 4'(a_ok);
        end
        @(negedge clk);
    endtask

    task automatic step();
        settle();
        advance();
    endtask

    task automatic idle();
        alloc_valid = 0; sta_valid = 0; std_valid = 0; retire = 0; flush = 0; ld_valid = 0;
        sta_idx = 0; sta_addr = 0; sta_size = 0; std_idx = 0; std_data = 0;
        ld_addr = 0; ld_size = 0; ld_snap = 0;
    endtask

    task automatic load(input logic [15:0] a, input logic [1:0] s, input logic [3:0] snap);
        idle();
        ld_valid = 1; ld_addr = a; ld_size = s; ld_snap = snap;
        settle();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 8; i++) begin mst[i] = 0; maddr[i] = 0; msz[i] = 0; mdat[i] = 0; end
        mh = 0; mr = 0; mt = 0;
        idle(); drain_ready = 0; rst_n = 0;
        @(negedge clk);
        advance(); advance();
        rst_n = 1;
        settle();
        chk("R1 reset ready", {31'd0, alloc_ready}, 32'd1);
        chk("R1 reset tag", {28'd0, alloc_tag}, 32'd0);
        chk("R4 reset drain", {31'd0, drain_valid}, 32'd0);
        chk("R6 reset res", {30'd0, ld_res}, 32'd0);
        advance();

        // data half first, then address half
        idle(); alloc_valid = 1; step();
        idle(); std_valid = 1; std_idx = 0; std_data = 32'hAABBCCDD; step();
        load(16'h0100, 2'd2, 4'd1);
        chk("R8 addr missing", {30'd0, ld_res}, 32'd2);
        advance();
        idle(); sta_valid = 1; sta_idx = 0; sta_addr = 16'h0100; sta_size = 2'd2; step();
        load(16'h0100, 2'd1, 4'd1);
        chk("R2 either order", {30'd0, ld_res}, 32'd1);
        chk("R10 masked data", ld_data, 32'h0000CCDD);
        advance();

        // one-byte store inside the four-byte one
        idle(); alloc_valid = 1; step();
        idle(); sta_valid = 1; sta_idx = 1; sta_addr = 16'h0102; sta_size = 2'd0; step();
        load(16'h0100, 2'd2, 4'd2);
        chk("R9 data missing", {30'd0, ld_res}, 32'd2);
        advance();
        idle(); std_valid = 1; std_idx = 1; std_data = 32'h00000055; step();
        load(16'h0100, 2'd2, 4'd2);
        chk("R11 partial", {30'd0, ld_res}, 32'd3);
        advance();
        load(16'h0102, 2'd0, 4'd2);
        chk("R7 youngest", {30'd0, ld_res}, 32'd1);
        chk("R7 youngest data", ld_data, 32'h00000055);
        advance();
        load(16'h0100, 2'd2, 4'd1);
        chk("R5 older only", {30'd0, ld_res}, 32'd1);
        chk("R5 older data", ld_data, 32'hAABBCCDD);
        advance();
        load(16'h0100, 2'd2, 4'd15);
        chk("R5 before head", {30'd0, ld_res}, 32'd0);
        advance();
        idle(); ld_addr = 16'h0100; settle();
        chk("R6 no lookup", {30'd0, ld_res}, 32'd0);
        advance();

        // retire ordering and ignored retire
        idle(); retire = 1; step();
        idle(); alloc_valid = 1; step();
        idle(); retire = 1; step();
        idle(); retire = 1; step();
        idle(); sta_valid = 1; sta_idx = 2; sta_addr = 16'h0108; sta_size = 2'd2;
        std_valid = 1; std_idx = 2; std_data = 32'h12345678; step();
        idle(); flush = 1; step();
        idle(); settle();
        chk("R3 ignored retire", {28'd0, alloc_tag}, 32'd2);
        advance();
        idle(); drain_ready = 1; settle();
        chk("R4 first drain", {16'd0, drain_addr}, 32'h0100);
        advance();
        settle();
        chk("R4 second drain", {16'd0, drain_addr}, 32'h0102);
        advance();
        settle();
        chk("R4 empty", {31'd0, drain_valid}, 32'd0);
        advance();

        // fill to full, then flush against an allocation
        drain_ready = 0;
        for (int i = 0; i < 8; i++) begin idle(); alloc_valid = 1; step(); end
        idle(); alloc_valid = 1; settle();
        chk("R1 full", {31'd0, alloc_ready}, 32'd0);
        advance();
        settle();
        chk("R1 full tag", {28'd0, alloc_tag}, 32'h0A);
        advance();
        idle(); flush = 1; alloc_valid = 1; step();
        idle(); settle();
        chk("R12 flush tag", {28'd0, alloc_tag}, 32'd2);
        chk("R12 flush ready", {31'd0, alloc_ready}, 32'd1);
        advance();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            idle();
            alloc_valid = ($urandom % 3) == 0;
            sta_valid   = ($urandom % 2) == 0;
            sta_idx     = 3'($urandom % 8);
            sta_addr    = 16'h0100 + 16'($urandom % 8);
            sta_size    = 2'($urandom % 3);
            std_valid   = ($urandom % 2) == 0;
            std_idx     = 3'($urandom % 8);
            std_data    = $urandom;
            retire      = ($urandom % 4) == 0;
            flush       = ($urandom % 40) == 0;
            drain_ready = ($urandom % 2) == 0;
            ld_valid    = ($urandom % 4) != 0;
            ld_addr     = 16'h0100 + 16'($urandom % 8);
            ld_size     = 2'($urandom % 3);
            ld_snap     = (($urandom % 16) == 0) ? (mh - 4'd1) : (mt - 4'($urandom % 3));
            step();
        end
        finish_run();
    end

endmodule